// File: doc/BRIEF.md
# Settings-Word Register Bridge

This block sits between a 32-bit write-only configuration port and the 8-bit register file of a serial-bus master. Every accepted configuration word carries one data byte and a four-bit selector. The selector's top bit marks the word as either a register write or a readback selection. A write word produces a one-cycle strobe for one of five target registers, with the data byte beside it. A readback-selection word writes nothing. It records which of the master's readable bytes appears, zero-extended, on a separate 32-bit readback port.

Software reads a register in two steps. It first posts a selection word. From the next cycle on, it samples the readback port. The readback value follows the selected source live and keeps following it until another selection word arrives. Word writes and idle cycles leave the selection unchanged.

The configuration input is a valid/ready stream. `cfg_ready` is low during reset and high at all other times, so the block never applies back-pressure. A word is taken on every clock edge where `cfg_valid` and `cfg_ready` are both high.

Top module: `cfg_byte_bridge`

## Requirements
- R1: While reset is asserted, and on the first sample after it: `wr_stb` is all zero, `rb_word` is zero and `cfg_ready` is low. `cfg_ready` is high from the first edge after reset is released.
- R2: A taken word with bit 11 = 1 and bits 10:8 = k, where k is 0 to 4, makes exactly `wr_stb[k]` high for exactly one cycle, one cycle after the word is taken. In that same cycle `wr_data` equals bits 7:0 of the word. Target order: 0 divider low byte, 1 divider high byte, 2 control, 3 transmit data, 4 command.
- R3: A taken word with bit 11 = 1 and bits 10:8 = 5, 6 or 7 raises no strobe and leaves the readback selection unchanged.
- R4: A taken word with bit 11 = 0 raises no strobe.
- R5: After a taken word with bit 11 = 0 and bits 10:8 = 3, `rb_word` equals `{24'b0, rx_byte}` from the next cycle on, and it follows later changes of `rx_byte`.
- R6: After a taken word with bit 11 = 0 and bits 10:8 = 4, `rb_word` equals `{24'b0, stat_byte}` from the next cycle on.
- R7: After a taken word with bit 11 = 0 and bits 10:8 not equal to 3 or 4, `rb_word` is zero. After reset the selection is 0, so `rb_word` reads zero.
- R8: The readback selection is kept through write words, ignored words and idle cycles until the next word with bit 11 = 0.
- R9: Bits 31:12 of a word have no effect on strobes, write data or readback.
- R10: Bits 31:8 of `rb_word` are always zero.
- R11: No word is taken while `cfg_valid` is low, and no strobe follows such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Word accepted when high; low only in reset |
| cfg_word | input | 32 | Word: bits 7:0 data, 10:8 index, 11 write flag |
| wr_stb | output | 5 | One-hot, one-cycle write strobes to target registers |
| wr_data | output | 8 | Byte for the strobed register |
| rx_byte | input | 8 | Received-data register of the master |
| stat_byte | input | 8 | Status register of the master |
| rb_word | output | 32 | Selected register, zero-extended |

## Verification
The hardest condition to reach is a held selection that must survive words which look like reads but are not. Examples are write words with unused indices 5 to 7, and words whose upper bits are set. The bench sweeps all sixteen selector codes, each with several data bytes and upper-bit patterns. It changes `rx_byte` and `stat_byte` between words, so a selection that is lost or wrongly reloaded shows up at the readback port. Every word is followed by an idle cycle, which exposes a strobe that lasts too long.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int WORD_W_D   = 32;
  localparam int BYTE_W_D   = 8;
  localparam int IDX_W_D    = 3;
  localparam int NUM_WREG_D = 5;
  localparam int RD_RX_D    = 3;
  localparam int RD_ST_D    = 4;
endpackage

// File: rtl/cfg_word_decode.sv
module cfg_word_decode #(
  parameter int WORD_W   = cfg_bridge_pkg::WORD_W_D,
  parameter int BYTE_W   = cfg_bridge_pkg::BYTE_W_D,
  parameter int IDX_W    = cfg_bridge_pkg::IDX_W_D,
  parameter int NUM_WREG = cfg_bridge_pkg::NUM_WREG_D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [WORD_W-1:0]   word,
  output logic [NUM_WREG-1:0] wr_stb,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                sel_load,
  output logic [IDX_W-1:0]    sel_idx
);
  localparam int IDX_LSB = BYTE_W;
  localparam int DIR_BIT = BYTE_W + IDX_W;

  logic             is_write;
  logic [IDX_W-1:0] idx;
  logic [NUM_WREG-1:0] stb_d;

  assign is_write = word[DIR_BIT];
  assign idx      = word[IDX_LSB +: IDX_W];
  assign sel_load = take && !is_write;
  assign sel_idx  = idx;

  for (genvar g = 0; g < NUM_WREG; g++) begin : g_stb
    assign stb_d[g] = take && is_write && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_stb  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= stb_d;
      if (take && is_write) wr_data <= word[BYTE_W-1:0];
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)); // R2
  AST_NO_STB_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !word[DIR_BIT]) |=> (wr_stb == '0)); // R4
  AST_NO_STB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (wr_stb == '0)); // R11
  AST_STB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (take && word[DIR_BIT] && (word[IDX_LSB +: IDX_W] < IDX_W'(NUM_WREG)))
      |=> (wr_data == $past(word[BYTE_W-1:0]))); // R2
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback #(
  parameter int WORD_W = cfg_bridge_pkg::WORD_W_D,
  parameter int BYTE_W = cfg_bridge_pkg::BYTE_W_D,
  parameter int IDX_W  = cfg_bridge_pkg::IDX_W_D,
  parameter int RD_RX  = cfg_bridge_pkg::RD_RX_D,
  parameter int RD_ST  = cfg_bridge_pkg::RD_ST_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_load,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] stat_byte,
  output logic [WORD_W-1:0] rb_word
);
  localparam int PAD_W = WORD_W - BYTE_W;

  logic [IDX_W-1:0]  sel_q;
  logic [BYTE_W-1:0] byte_mux;

  always_ff @(posedge clk) begin
    if (!rst_n)        sel_q <= '0;
    else if (sel_load) sel_q <= sel_idx;
  end

  always_comb begin
    if (sel_q == IDX_W'(RD_RX))      byte_mux = rx_byte;
    else if (sel_q == IDX_W'(RD_ST)) byte_mux = stat_byte;
    else                             byte_mux = '0;
  end

  assign rb_word = {{PAD_W{1'b0}}, byte_mux};

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_load |=> $stable(sel_q)); // R8
  AST_SEL_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && sel_idx == IDX_W'(RD_RX)) |=> (rb_word[BYTE_W-1:0] == rx_byte)); // R5
  always_comb begin
    AST_UPPER_ZERO: assert (rb_word[WORD_W-1:BYTE_W] == '0); // R10
  end
endmodule

// File: rtl/cfg_byte_bridge.sv
module cfg_byte_bridge #(
  parameter int WORD_W   = cfg_bridge_pkg::WORD_W_D,
  parameter int BYTE_W   = cfg_bridge_pkg::BYTE_W_D,
  parameter int IDX_W    = cfg_bridge_pkg::IDX_W_D,
  parameter int NUM_WREG = cfg_bridge_pkg::NUM_WREG_D,
  parameter int RD_RX    = cfg_bridge_pkg::RD_RX_D,
  parameter int RD_ST    = cfg_bridge_pkg::RD_ST_D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [WORD_W-1:0]   cfg_word,
  output logic [NUM_WREG-1:0] wr_stb,
  output logic [BYTE_W-1:0]   wr_data,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic [BYTE_W-1:0]   stat_byte,
  output logic [WORD_W-1:0]   rb_word
);
  logic             take;
  logic             sel_load;
  logic [IDX_W-1:0] sel_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_ready <= 1'b0;
    else        cfg_ready <= 1'b1;
  end

  assign take = cfg_valid && cfg_ready;

  cfg_word_decode #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W),
                    .NUM_WREG(NUM_WREG)) u_dec (
    .clk(clk), .rst_n(rst_n), .take(take), .word(cfg_word),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .sel_load(sel_load), .sel_idx(sel_idx));

  cfg_readback #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W),
                 .RD_RX(RD_RX), .RD_ST(RD_ST)) u_rb (
    .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .sel_idx(sel_idx),
    .rx_byte(rx_byte), .stat_byte(stat_byte), .rb_word(rb_word));

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cfg_ready); // R1
endmodule

// File: tb/sim_cfg_byte_bridge.sv
module sim_cfg_byte_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [31:0] cfg_word = '0;
  logic [4:0]  wr_stb;
  logic [7:0]  wr_data;
  logic [7:0]  rx_byte = 8'h11;
  logic [7:0]  stat_byte = 8'h22;
  logic [31:0] rb_word;

  int n_cmp = 0;
  int n_bad = 0;
  int sel_exp = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_byte_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .wr_stb(wr_stb), .wr_data(wr_data),
    .rx_byte(rx_byte), .stat_byte(stat_byte), .rb_word(rb_word));

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rb_model();
    if (sel_exp == 3) return {24'b0, rx_byte};
    if (sel_exp == 4) return {24'b0, stat_byte};
    return 32'h0;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  dat [5] = '{8'h00, 8'h5A, 8'hA5, 8'hFF, 8'h3C};
    logic [19:0] upp [3] = '{20'h00000, 20'hFFFFF, 20'h5A5A5};
    @(negedge clk);
    chk({31'b0, cfg_ready}, 32'h0, "R1 ready in reset");
    chk({27'b0, wr_stb}, 32'h0, "R1 strobes in reset");
    chk(rb_word, 32'h0, "R1 readback in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'b0, cfg_ready}, 32'h1, "R1 ready after reset");
    chk(rb_word, 32'h0, "R7 reset selection reads zero");
    for (int u = 0; u < 3; u++) begin
      for (int c = 0; c < 16; c++) begin
        for (int d = 0; d < 5; d++) begin
          logic [7:0] db;
          logic [4:0] stb_e;
          db = dat[d] ^ 8'(c * 17);
          cfg_word  = {upp[u], 4'(c), db};
          cfg_valid = 1'b1;
          @(negedge clk);
          cfg_valid = 1'b0;
          cfg_word  = ~cfg_word;
          stb_e = 5'b0;
          if (c >= 8 && c <= 12) stb_e[c-8] = 1'b1;
          if (c < 8) sel_exp = c;
          chk({27'b0, wr_stb}, {27'b0, stb_e},
              c < 8 ? "R4 no strobe on select" : (c > 12 ? "R3 ignored index" : "R2/R9 strobe"));
          if (c >= 8 && c <= 12) chk({24'b0, wr_data}, {24'b0, db}, "R2/R9 write data");
          chk(rb_word, rb_model(), c == 3 ? "R5 rx select" : (c == 4 ? "R6 status select" :
              (c < 8 ? "R7 other select" : "R8 selection held")));
          rx_byte   = rx_byte + 8'h13;
          stat_byte = stat_byte ^ 8'h5F;
          #1;
          chk(rb_word, rb_model(), "R5/R6 live follow R10");
          @(negedge clk);
          chk({27'b0, wr_stb}, 32'h0, "R11 idle no strobe");
          chk(rb_word, rb_model(), "R8 held over idle");
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule